// File: doc/BRIEF.md
# NAND Flash Control and Strobe-Timing Register

This block is the control register that sits between a processor's byte-wide register bus and the pins of a NAND flash device. It holds one 16-bit control word, exposed as two byte locations. Most bits drive flash pins or downstream engines as plain levels. The latch-control bits drive their pins at the same level as the bit. The chip-enable bits drive their pins inverted. Other bits are enables and mode levels for the error-correction engines.

The block also produces the read and write strobes for data transfers. Each transfer has a low phase and a high phase, and the length of each phase is a register field counted in system clocks. The data path raises a one-cycle request and gets a one-cycle acknowledge once both phases are finished.

The flash ready/busy pin is first synchronized and then passed through an agreement filter before it appears as a read-only status bit. Writing 1 to one of two self-clearing command bits produces a single-cycle pulse. One of these pulses clears the error-correction engine chosen by an external select input. The other starts the Reed-Solomon error calculation.

Top module: `nand_ctl_unit`

## Requirements
- R1: After synchronous reset, both register bytes read 0. Address-latch and command-latch outputs are low, both chip-enable outputs are high, both strobes are high, and every pulse and acknowledge output is low.
- R2: In the low byte (address 0), bit 7 is write-strobe enable, bit 6 is address-latch level, bit 5 is command-latch level, bit 4 is chip-enable 0, bit 3 is chip-enable 1 and bit 2 is ECC enable. The latch pins follow their bits directly. Each chip-enable pin is the inverse of its bit. These bits read back as written.
- R3: In the high byte (address 1), bits 7:6 are the strobe low width and bits 5:4 are the strobe high width. Bit 3 is the Reed-Solomon latch enable, bit 2 is the Reed-Solomon direction (1 = decode) and bit 0 is the Reed-Solomon generator write enable. These bits read back as written and drive their level outputs.
- R4: Low-byte bit 0 and high-byte bit 1 always read 0. Low-byte bit 1 is the busy status; writes to it have no effect on the value read.
- R5: Writing 1 to low-byte bit 0 while the stored ECC enable is 1 gives a one-cycle clear pulse in the cycle after the write. The pulse goes to the Hamming clear output when the ECC select input is 0 and to the Reed-Solomon clear output when it is 1.
- R6: Writing 1 to low-byte bit 0 while the stored ECC enable is 0 produces no clear pulse on either output.
- R7: Writing 1 to high-byte bit 1 produces a one-cycle Reed-Solomon start pulse in the cycle after the write.
- R8: The busy status reads 1 when the ready/busy pin is low and 0 when it is high. The status changes only after the synchronized pin has held its new value for 4 consecutive clocks: a pin change made just after clock edge k shows up after edge k+6. A pulse of 3 cycles or less is ignored.
- R9: A strobe's low phase lasts exactly as many clocks as the low-width field and its high phase as many clocks as the high-width field. A field value of 0 counts as 1.
- R10: A request accepted while idle is acknowledged for one cycle after the high phase ends. A request made while a strobe is running is ignored, and only one strobe is active at a time.
- R11: When write-strobe enable is 0, a write transfer keeps the write strobe high, but it still runs its timing and is acknowledged.
- R12: The widths and direction are captured when a request is accepted. A register write during a running strobe affects only later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| ecc_sel | input | 1 | Engine select for the clear pulse: 0 Hamming, 1 Reed-Solomon |
| rb_n | input | 1 | Flash ready/busy pin, low = busy |
| stb_req | input | 1 | One-cycle transfer request from the data path |
| stb_is_write | input | 1 | Direction of the requested transfer, 1 = write |
| stb_ack | output | 1 | One-cycle transfer completion |
| cle_o | output | 1 | Command-latch pin |
| ale_o | output | 1 | Address-latch pin |
| ce0_n_o | output | 1 | Chip-enable 0 pin, active low |
| ce1_n_o | output | 1 | Chip-enable 1 pin, active low |
| re_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| ecc_en_o | output | 1 | ECC circuit enable level |
| ham_clr_o | output | 1 | Hamming engine clear pulse |
| rs_clr_o | output | 1 | Reed-Solomon engine clear pulse |
| rs_latch_o | output | 1 | Reed-Solomon latch enable level |
| rs_decode_o | output | 1 | Reed-Solomon direction level, 1 = decode |
| rs_start_o | output | 1 | Reed-Solomon calculation start pulse |
| rs_gen_wr_o | output | 1 | Reed-Solomon generator write enable level |

## Verification
A register write to the width byte can land in the same cycles as a running strobe. To provoke this, the bench writes new widths while a 3+3 strobe is still in its low phase. The running strobe must keep its captured widths, and the next strobe must use the new ones.

The scoreboard judges each transfer by the number of low cycles on each strobe and the total number of cycles up to the acknowledge. A second request, raised in the middle of a transfer, must not produce an extra acknowledge.

// File: rtl/nand_ctl_pkg.sv
package nand_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int WID_W  = 2;

    // low byte bit positions
    localparam int LB_WE_EN = 7;
    localparam int LB_ALE   = 6;
    localparam int LB_CLE   = 5;
    localparam int LB_CE0   = 4;
    localparam int LB_CE1   = 3;
    localparam int LB_ECCEN = 2;
    localparam int LB_BUSY  = 1;
    localparam int LB_ECCRS = 0;

    // high byte bit positions
    localparam int HB_LOW_HI  = 7;
    localparam int HB_LOW_LO  = 6;
    localparam int HB_HIGH_HI = 5;
    localparam int HB_HIGH_LO = 4;
    localparam int HB_LATCH   = 3;
    localparam int HB_DECODE  = 2;
    localparam int HB_START   = 1;
    localparam int HB_GENWR   = 0;

    typedef struct packed {
        logic we_en;
        logic ale;
        logic cle;
        logic ce0;
        logic ce1;
        logic ecc_en;
    } low_cfg_t;

    typedef struct packed {
        logic [WID_W-1:0] lo_w;
        logic [WID_W-1:0] hi_w;
        logic             rs_latch;
        logic             rs_decode;
        logic             rs_gen_wr;
    } high_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_ACK  = 2'd3
    } stb_state_e;

    // counter load for a phase: a zero field still gives one cycle
    function automatic logic [WID_W-1:0] phase_load(input logic [WID_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_low(input low_cfg_t c, input logic busy);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[LB_WE_EN] = c.we_en;
        b[LB_ALE]   = c.ale;
        b[LB_CLE]   = c.cle;
        b[LB_CE0]   = c.ce0;
        b[LB_CE1]   = c.ce1;
        b[LB_ECCEN] = c.ecc_en;
        b[LB_BUSY]  = busy;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_high(input high_cfg_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[HB_LOW_HI:HB_LOW_LO]   = c.lo_w;
        b[HB_HIGH_HI:HB_HIGH_LO] = c.hi_w;
        b[HB_LATCH]  = c.rs_latch;
        b[HB_DECODE] = c.rs_decode;
        b[HB_GENWR]  = c.rs_gen_wr;
        return b;
    endfunction

    function automatic low_cfg_t unpack_low(input logic [BYTE_W-1:0] b);
        low_cfg_t c;
        c.we_en  = b[LB_WE_EN];
        c.ale    = b[LB_ALE];
        c.cle    = b[LB_CLE];
        c.ce0    = b[LB_CE0];
        c.ce1    = b[LB_CE1];
        c.ecc_en = b[LB_ECCEN];
        return c;
    endfunction

    function automatic high_cfg_t unpack_high(input logic [BYTE_W-1:0] b);
        high_cfg_t c;
        c.lo_w      = b[HB_LOW_HI:HB_LOW_LO];
        c.hi_w      = b[HB_HIGH_HI:HB_HIGH_LO];
        c.rs_latch  = b[HB_LATCH];
        c.rs_decode = b[HB_DECODE];
        c.rs_gen_wr = b[HB_GENWR];
        return c;
    endfunction

endpackage

// File: rtl/nand_ctl_regfile.sv
module nand_ctl_regfile
    import nand_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ecc_sel,
    input  logic              busy,
    output low_cfg_t          lo_cfg,
    output high_cfg_t         hi_cfg,
    output logic [BYTE_W-1:0] rdata,
    output logic              ham_clr,
    output logic              rs_clr,
    output logic              rs_start
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cfg   <= '0;
            hi_cfg   <= '0;
            ham_clr  <= 1'b0;
            rs_clr   <= 1'b0;
            rs_start <= 1'b0;
        end else begin
            ham_clr  <= 1'b0;
            rs_clr   <= 1'b0;
            rs_start <= 1'b0;
            if (wr_en) begin
                if (!addr) begin
                    lo_cfg <= unpack_low(wdata);
                    // the stored enable, not the byte being written, gates the clear
                    if (wdata[LB_ECCRS] && lo_cfg.ecc_en) begin
                        ham_clr <= !ecc_sel;
                        rs_clr  <= ecc_sel;
                    end
                end else begin
                    hi_cfg   <= unpack_high(wdata);
                    rs_start <= wdata[HB_START];
                end
            end
        end
    end

    always_comb begin
        rdata = addr ? pack_high(hi_cfg) : pack_low(lo_cfg, busy);
    end

    p_clr_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(ham_clr && rs_clr));

    p_clr_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        (ham_clr || rs_clr) |-> $past(lo_cfg.ecc_en));

    p_start_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        rs_start |-> $past(wr_en && addr));

endmodule

// File: rtl/nand_rb_filter.sv
module nand_rb_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_n,
    output logic busy
);

    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       agree_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            agree_cnt <= '0;
            busy      <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ~rb_n};
            if (synced == busy) begin
                agree_cnt <= '0;
            end else if (agree_cnt == CNT_LAST) begin
                busy      <= synced;
                agree_cnt <= '0;
            end else begin
                agree_cnt <= agree_cnt + 1'b1;
            end
        end
    end

    p_busy_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(busy) |-> $past(agree_cnt) == CNT_LAST);

    p_busy_takes_sync_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(busy) |-> busy == $past(synced));

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             is_write,
    input  logic             we_en,
    input  logic [WID_W-1:0] lo_w,
    input  logic [WID_W-1:0] hi_w,
    output logic             re_n,
    output logic             we_n,
    output logic             ack
);

    stb_state_e       state;
    logic [WID_W-1:0] cnt;
    logic [WID_W-1:0] hi_q;
    logic             dir_q;
    logic             low_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            hi_q  <= '0;
            dir_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    state <= ST_LOW;
                    cnt   <= phase_load(lo_w);
                    hi_q  <= hi_w;
                    dir_q <= is_write;
                end
                ST_LOW: if (cnt == '0) begin
                    state <= ST_HIGH;
                    cnt   <= phase_load(hi_q);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_HIGH: if (cnt == '0) begin
                    state <= ST_ACK;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_ACK: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        low_ph = (state == ST_LOW);
        re_n   = !(low_ph && !dir_q);
        we_n   = !(low_ph && dir_q && we_en);
        ack    = (state == ST_ACK);
    end

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        re_n || we_n);

    p_ack_after_high_r10: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(state) == ST_HIGH);

    p_start_needs_req_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW && $past(state) == ST_IDLE) |-> $past(req));

endmodule

// File: rtl/nand_ctl_unit.sv
module nand_ctl_unit
    import nand_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ecc_sel,
    input  logic       rb_n,
    input  logic       stb_req,
    input  logic       stb_is_write,
    output logic       stb_ack,
    output logic       cle_o,
    output logic       ale_o,
    output logic       ce0_n_o,
    output logic       ce1_n_o,
    output logic       re_n_o,
    output logic       we_n_o,
    output logic       ecc_en_o,
    output logic       ham_clr_o,
    output logic       rs_clr_o,
    output logic       rs_latch_o,
    output logic       rs_decode_o,
    output logic       rs_start_o,
    output logic       rs_gen_wr_o
);

    low_cfg_t  lo_cfg;
    high_cfg_t hi_cfg;
    logic      busy;

    nand_ctl_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ecc_sel  (ecc_sel),
        .busy     (busy),
        .lo_cfg   (lo_cfg),
        .hi_cfg   (hi_cfg),
        .rdata    (bus_rdata),
        .ham_clr  (ham_clr_o),
        .rs_clr   (rs_clr_o),
        .rs_start (rs_start_o)
    );

    nand_rb_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_filt (
        .clk  (clk),
        .rst  (rst),
        .rb_n (rb_n),
        .busy (busy)
    );

    nand_strobe_gen u_stb (
        .clk      (clk),
        .rst      (rst),
        .req      (stb_req),
        .is_write (stb_is_write),
        .we_en    (lo_cfg.we_en),
        .lo_w     (hi_cfg.lo_w),
        .hi_w     (hi_cfg.hi_w),
        .re_n     (re_n_o),
        .we_n     (we_n_o),
        .ack      (stb_ack)
    );

    always_comb begin
        cle_o       = lo_cfg.cle;
        ale_o       = lo_cfg.ale;
        ce0_n_o     = !lo_cfg.ce0;
        ce1_n_o     = !lo_cfg.ce1;
        ecc_en_o    = lo_cfg.ecc_en;
        rs_latch_o  = hi_cfg.rs_latch;
        rs_decode_o = hi_cfg.rs_decode;
        rs_gen_wr_o = hi_cfg.rs_gen_wr;
    end

endmodule

// File: tb/nand_ctl_unit_test.sv
module nand_ctl_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ecc_sel = 1'b0;
    logic       rb_n = 1'b1;
    logic       stb_req = 1'b0;
    logic       stb_is_write = 1'b0;
    logic       stb_ack;
    logic       cle_o, ale_o, ce0_n_o, ce1_n_o, re_n_o, we_n_o;
    logic       ecc_en_o, ham_clr_o, rs_clr_o, rs_latch_o, rs_decode_o, rs_start_o, rs_gen_wr_o;

    always #5 clk = ~clk;

    nand_ctl_unit uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ecc_sel(ecc_sel),
        .rb_n(rb_n), .stb_req(stb_req), .stb_is_write(stb_is_write),
        .stb_ack(stb_ack), .cle_o(cle_o), .ale_o(ale_o), .ce0_n_o(ce0_n_o),
        .ce1_n_o(ce1_n_o), .re_n_o(re_n_o), .we_n_o(we_n_o),
        .ecc_en_o(ecc_en_o), .ham_clr_o(ham_clr_o), .rs_clr_o(rs_clr_o),
        .rs_latch_o(rs_latch_o), .rs_decode_o(rs_decode_o),
        .rs_start_o(rs_start_o), .rs_gen_wr_o(rs_gen_wr_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int acks_seen = 0;
    int acks_exp  = 0;
    bit done = 1'b0;

    typedef struct {
        int    lo_re;
        int    lo_we;
        int    tot;
        string tag;
    } stb_exp_t;

    stb_exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input string what, input int act, input int exp);
        check(act == exp, tag, what, act, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // monitor: measures each transfer and compares against the queue
    bit mon_active = 1'b0;
    int m_re = 0, m_we = 0, m_tot = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mon_active) begin
                if (stb_ack) begin
                    acks_seen++;
                    check(1'b0, "R10", "acknowledge with no transfer", 1, 0);
                end
                if (stb_req) begin
                    mon_active = 1'b1;
                    m_re = 0; m_we = 0; m_tot = 0;
                end
            end else if (stb_ack) begin
                stb_exp_t e;
                acks_seen++;
                mon_active = 1'b0;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "acknowledge with empty scoreboard", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk_eq(e.tag, "read strobe low cycles", m_re, e.lo_re);
                    chk_eq(e.tag, "write strobe low cycles", m_we, e.lo_we);
                    chk_eq(e.tag, "cycles to acknowledge", m_tot, e.tot);
                end
            end else begin
                m_tot++;
                if (!re_n_o) m_re++;
                if (!we_n_o) m_we++;
            end
        end
    end

    task automatic wr_reg(input bit a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input bit a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic push_exp(input bit wr, input int lf, input int hf, input bit we_on,
                            input string tag);
        stb_exp_t e;
        int l, h;
        l = (lf == 0) ? 1 : lf;
        h = (hf == 0) ? 1 : hf;
        e.lo_re = wr ? 0 : l;
        e.lo_we = (wr && we_on) ? l : 0;
        e.tot   = l + h;
        e.tag   = tag;
        sb_q.push_back(e);
        acks_exp++;
    endtask

    task automatic wait_ack();
        int n;
        n = 0;
        while (!stb_ack && n < 40) begin
            @(posedge clk); #1;
            n++;
        end
        chk_eq("R10", "acknowledge arrived", int'(stb_ack), 1);
        @(posedge clk); #1;
    endtask

    task automatic pulse_req(input bit wr);
        @(posedge clk); #1;
        stb_req = 1'b1; stb_is_write = wr;
        @(posedge clk); #1;
        stb_req = 1'b0;
    endtask

    task automatic do_strobe(input bit wr, input int lf, input int hf, input bit we_on,
                             input string tag);
        push_exp(wr, lf, hf, we_on, tag);
        pulse_req(wr);
        wait_ack();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_reg(1'b0, v); chk_eq("R1", "low byte after reset", v, 0);
        rd_reg(1'b1, v); chk_eq("R1", "high byte after reset", v, 0);
        chk_eq("R1", "pins {cle,ale,ce0_n,ce1_n,re_n,we_n}",
               int'({cle_o, ale_o, ce0_n_o, ce1_n_o, re_n_o, we_n_o}), 'b001111);
        chk_eq("R1", "pulses and ack", int'({ham_clr_o, rs_clr_o, rs_start_o, stb_ack}), 0);

        // R2 pin levels and readback
        wr_reg(1'b0, 8'hF8);
        chk_eq("R2", "pins all set {cle,ale,ce0_n,ce1_n}",
               int'({cle_o, ale_o, ce0_n_o, ce1_n_o}), 'b1100);
        rd_reg(1'b0, v); chk_eq("R2", "low byte readback", v, 'hF8);
        wr_reg(1'b0, 8'h50);
        chk_eq("R2", "pins mixed {cle,ale,ce0_n,ce1_n}",
               int'({cle_o, ale_o, ce0_n_o, ce1_n_o}), 'b0101);

        // R6: clear while enable stored 0; R4: busy bit not writable
        wr_reg(1'b0, 8'h07);
        chk_eq("R6", "clear pulses with enable off", int'({ham_clr_o, rs_clr_o}), 0);
        @(posedge clk); #1;
        chk_eq("R6", "clear pulses next cycle", int'({ham_clr_o, rs_clr_o}), 0);
        rd_reg(1'b0, v); chk_eq("R4", "busy and clear bits read 0", v, 'h04);
        chk_eq("R2", "ecc enable level", int'(ecc_en_o), 1);

        // R5 routing
        ecc_sel = 1'b0;
        wr_reg(1'b0, 8'h05);
        chk_eq("R5", "Hamming clear {ham,rs}", int'({ham_clr_o, rs_clr_o}), 'b10);
        @(posedge clk); #1;
        chk_eq("R5", "Hamming clear one cycle", int'({ham_clr_o, rs_clr_o}), 0);
        ecc_sel = 1'b1;
        wr_reg(1'b0, 8'h05);
        chk_eq("R5", "Reed-Solomon clear {ham,rs}", int'({ham_clr_o, rs_clr_o}), 'b01);
        @(posedge clk); #1;
        chk_eq("R5", "Reed-Solomon clear one cycle", int'({ham_clr_o, rs_clr_o}), 0);
        rd_reg(1'b0, v); chk_eq("R4", "clear bit reads 0", v, 'h04);

        // R3 high byte
        wr_reg(1'b1, 8'hFD);
        rd_reg(1'b1, v); chk_eq("R3", "high byte readback", v, 'hFD);
        chk_eq("R3", "levels {latch,decode,genwr}",
               int'({rs_latch_o, rs_decode_o, rs_gen_wr_o}), 'b111);
        // R7 start pulse
        wr_reg(1'b1, 8'h02);
        chk_eq("R7", "start pulse", int'(rs_start_o), 1);
        @(posedge clk); #1;
        chk_eq("R7", "start pulse one cycle", int'(rs_start_o), 0);
        rd_reg(1'b1, v); chk_eq("R4", "start bit reads 0", v, 0);

        // R9 strobe widths
        wr_reg(1'b0, 8'h84);
        wr_reg(1'b1, 8'hB0);
        do_strobe(1'b0, 2, 3, 1'b1, "R9");
        do_strobe(1'b1, 2, 3, 1'b1, "R9");
        wr_reg(1'b1, 8'h00);
        do_strobe(1'b0, 0, 0, 1'b1, "R9");
        wr_reg(1'b1, 8'hD0);
        do_strobe(1'b1, 3, 1, 1'b1, "R9");

        // R11 write strobe suppressed
        wr_reg(1'b0, 8'h04);
        do_strobe(1'b1, 3, 1, 1'b0, "R11");
        wr_reg(1'b0, 8'h84);

        // R12 width write while a strobe runs
        wr_reg(1'b1, 8'hF0);
        push_exp(1'b0, 3, 3, 1'b1, "R12");
        pulse_req(1'b0);
        wr_reg(1'b1, 8'h50);
        wait_ack();
        do_strobe(1'b0, 1, 1, 1'b1, "R12");

        // R10 request during a strobe is ignored
        wr_reg(1'b1, 8'hF0);
        push_exp(1'b1, 3, 3, 1'b1, "R10");
        pulse_req(1'b1);
        @(posedge clk); #1;
        stb_req = 1'b1;
        @(posedge clk); #1;
        stb_req = 1'b0;
        wait_ack();
        repeat (12) @(posedge clk);
        #1;
        chk_eq("R10", "acknowledge count", acks_seen, acks_exp);

        // R8 busy filter
        @(posedge clk); #1;
        rb_n = 1'b0;
        repeat (5) @(posedge clk);
        #1; rd_reg(1'b0, v);
        chk_eq("R8", "busy not yet visible", (v >> 1) & 1, 0);
        @(posedge clk); #1; rd_reg(1'b0, v);
        chk_eq("R8", "busy visible after edge 6", (v >> 1) & 1, 1);
        rb_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 rb_n = 1'b0;
        repeat (10) @(posedge clk);
        #1; rd_reg(1'b0, v);
        chk_eq("R8", "3-cycle ready glitch ignored", (v >> 1) & 1, 1);
        rb_n = 1'b1;
        repeat (6) @(posedge clk);
        #1; rd_reg(1'b0, v);
        chk_eq("R8", "ready after hold", (v >> 1) & 1, 0);
        wr_reg(1'b0, 8'h86);
        rd_reg(1'b0, v);
        chk_eq("R4", "busy bit ignores writes", (v >> 1) & 1, 0);

        chk_eq("R10", "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule